// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor. It receives the accumulator value and one second operand, which may come from a register, a memory byte or an immediate field. It also receives an operation code. From these inputs it computes the new 8-bit result combinationally.

The block keeps five status flags in a register: sign, zero, auxiliary carry, parity and carry. The stored carry and auxiliary carry feed back into the carry-chained operations and into the decimal adjust step. The flags are written on a clock edge, and only when the write strobe is high. Operand fetch, instruction decode and memory access are outside the block.

The block has no sequencer. The opcode selects one of twelve operating modes, named below, and the four opcodes left over select a pass mode. The only stored state is the flag register. It leaves reset cleared. On an edge with the strobe high it moves to the flags of the current mode. On an edge with the strobe low it holds.

| Opcode | Mode | Result |
|---|---|---|
| 0 | ADD | acc + opnd |
| 1 | ADC | acc + opnd + carry |
| 2 | SUB | acc - opnd |
| 3 | SBB | acc - opnd - carry |
| 4 | AND | acc & opnd |
| 5 | OR | acc \| opnd |
| 6 | XOR | acc ^ opnd |
| 7 | CPL_ACC | ~acc |
| 8 | CPL_CY | acc |
| 9 | INC | opnd + 1 |
| 10 | DEC | opnd - 1 |
| 11 | DEC_ADJ | decimal adjust of acc |
| 12-15 | pass | acc |

Top module: `acc_alu`

## Requirements
- R1: After reset, `flags_o` is 5'b00000 until the first strobed write. The flag vector packs the flags as {sign, zero, aux, parity, carry}, with sign at bit 4 and carry at bit 0.
- R2: Opcode 0 (add) gives acc+opnd and ignores the stored carry. Opcode 1 (add with carry) gives acc+opnd+carry. For both, carry is the carry out of bit 7 and aux is the carry out of bit 3.
- R3: Opcode 2 (subtract) gives acc-opnd and ignores the stored carry. Opcode 3 (subtract with borrow) gives acc-opnd-carry. For both, carry is set when opnd plus borrow-in exceeds acc, and aux is set on a borrow out of the low nibble.
- R4: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of acc and opnd. Each clears both carry and aux.
- R5: Opcode 7 gives the inversion of all acc bits (FF becomes 00) and leaves every flag unchanged.
- R6: Opcode 8 passes acc through as the result, inverts carry and leaves the other four flags unchanged.
- R7: Opcode 9 gives opnd+1 and opcode 10 gives opnd-1. Carry is kept. Aux reports the carry or borrow of the low nibble.
- R8: Opcode 11 (decimal adjust, meant for use after an addition) works in two steps. First it adds 06 when the low nibble of acc is above 9 or aux is set. Then it adds 60 when the intermediate high nibble is above 9, the first step overflowed, or carry is set. Carry is set when the 60 correction is made and cleared otherwise. Aux is the low-nibble carry of the first step.
- R9: Every flag-writing opcode except 7 and 8 sets sign to result bit 7, sets zero when the result is 00, and sets parity when the result has an even number of 1 bits.
- R10: `result_o` follows the inputs within the same cycle. `flags_o` changes only at a clock edge on which `wr_en_i` is high, and otherwise holds.
- R11: Opcodes 12 to 15 pass acc through as the result and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand: a register, a memory byte or an immediate |
| wr_en_i | input | 1 | Flag write strobe |
| result_o | output | 8 | Combinational result |
| flags_o | output | 5 | Stored flags {sign, zero, aux, parity, carry} |

## Verification
The result is due in the same cycle as its inputs. The flags are due one rising edge after a cycle in which the strobe is high.

The bench drives its inputs at the falling edge and reads `result_o` 1 ns later, before any edge. It raises the strobe for that cycle and reads `flags_o` at the next falling edge.

Before each vector, the bench presets the carry and aux flags with a known add, because the later modes depend on those stored flags. A separate case leaves the strobe low and confirms that the flags hold.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 4;
    localparam int FW  = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 4'd0,
        OP_ADC    = 4'd1,
        OP_SUB    = 4'd2,
        OP_SBB    = 4'd3,
        OP_AND    = 4'd4,
        OP_OR     = 4'd5,
        OP_XOR    = 4'd6,
        OP_CPLA   = 4'd7,
        OP_CPLC   = 4'd8,
        OP_INC    = 4'd9,
        OP_DEC    = 4'd10,
        OP_DADJ   = 4'd11,
        OP_RSV12  = 4'd12,
        OP_RSV13  = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o,
    output logic          ac_o
);
    // Subtraction is done as a + ~b + ~borrow; both carry-outs are inverted on the way out.
    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic [DW:0]   sum;
    logic [NW:0]   nib;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = sub_i ? ~cin_i : cin_i;
        sum   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
        nib   = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c_eff};
        res_o = sum[DW-1:0];
        cy_o  = sum[DW] ^ sub_i;
        ac_o  = nib[NW] ^ sub_i;
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
    import alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic          ac_i,
    input  logic          cy_i,
    output logic [DW-1:0] res_o,
    output logic          ac_o,
    output logic          cy_o
);
    localparam logic [NW-1:0] NINE   = NW'(9);
    localparam logic [NW-1:0] LO_FIX = NW'(6);

    logic          lo_adj;
    logic          hi_adj;
    logic [NW:0]   lo_sum;
    logic [DW:0]   step1;

    always_comb begin
        lo_adj = (a_i[NW-1:0] > NINE) || ac_i;
        lo_sum = {1'b0, a_i[NW-1:0]} + {1'b0, (lo_adj ? LO_FIX : '0)};
        step1  = {1'b0, a_i} + {{(DW+1-NW){1'b0}}, (lo_adj ? LO_FIX : '0)};
        hi_adj = step1[DW] || (step1[DW-1:NW] > NINE) || cy_i;
        res_o  = step1[DW-1:0] + (hi_adj ? {LO_FIX, {NW{1'b0}}} : '0);
        ac_o   = lo_sum[NW];
        cy_o   = hi_adj;
    end
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
    import alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we_i,
    input  flags_t d_i,
    output flags_t q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_o <= '0;
        else if (we_i) q_o <= d_i;
    end

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  acc_i,
    input  logic [DW-1:0]  opnd_i,
    input  logic           wr_en_i,
    output logic [DW-1:0]  result_o,
    output logic [FW-1:0]  flags_o
);
    alu_op_e       op;
    flags_t        cur;
    flags_t        nxt;
    logic [DW-1:0] as_a, as_b, as_res, lg_res, da_res;
    logic          as_cin, as_sub, as_cy, as_ac, da_ac, da_cy;

    assign op = alu_op_e'(op_i);

    // Operand steering for the shared adder
    always_comb begin
        as_a   = acc_i;
        as_b   = opnd_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:  as_cin = cur.cy;
            OP_SUB:  as_sub = 1'b1;
            OP_SBB:  begin as_sub = 1'b1; as_cin = cur.cy; end
            OP_INC:  begin as_a = opnd_i; as_b = '0; as_cin = 1'b1; end
            OP_DEC:  begin as_a = opnd_i; as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub u_as (.a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
                     .res_o(as_res), .cy_o(as_cy), .ac_o(as_ac));
    alu_logic  u_lg (.a_i(acc_i), .b_i(opnd_i), .op_i(op), .res_o(lg_res));
    alu_decadj u_da (.a_i(acc_i), .ac_i(cur.ac), .cy_i(cur.cy),
                     .res_o(da_res), .ac_o(da_ac), .cy_o(da_cy));

    // Result select and next-flag computation
    always_comb begin
        nxt      = cur;
        result_o = acc_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                result_o = as_res;
                nxt.cy   = as_cy;
                nxt.ac   = as_ac;
            end
            OP_INC, OP_DEC: begin
                result_o = as_res;
                nxt.ac   = as_ac;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_o = lg_res;
                nxt.cy   = 1'b0;
                nxt.ac   = 1'b0;
            end
            OP_CPLA: result_o = lg_res;
            OP_CPLC: nxt.cy = ~cur.cy;
            OP_DADJ: begin
                result_o = da_res;
                nxt.cy   = da_cy;
                nxt.ac   = da_ac;
            end
            default: ;
        endcase
        if (!(op inside {OP_CPLA, OP_CPLC, OP_RSV12, OP_RSV13, OP_RSV14, OP_RSV15})) begin
            nxt.s = result_o[DW-1];
            nxt.z = (result_o == '0);
            nxt.p = ~^result_o;
        end
    end

    alu_flagreg u_fr (.clk(clk), .rst_n(rst_n), .we_i(wr_en_i), .d_i(nxt), .q_o(cur));

    assign flags_o = cur;

    // R7
    incdec_keep_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (op_i == OP_INC || op_i == OP_DEC)) |=> cur.cy == $past(cur.cy));
    // R4
    logic_clr_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=> (!cur.cy && !cur.ac));
    // R6
    cplc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == OP_CPLC) |=> cur.cy != $past(cur.cy));
    // R5
    cpla_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == OP_CPLA) |=> $stable(cur));
    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i <= OP_XOR) |=> cur.z == ($past(result_o) == '0));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 25;

    // {preset[1:0], op[3:0], acc[7:0], opnd[7:0], exp_res[7:0], exp_flags[4:0]}
    // preset: 0 -> flags 01010, 1 -> 01011 (carry), 2 -> 00100 (aux), 3 -> 01111
    localparam logic [34:0] VEC [NVEC] = '{
        {2'd0, 4'd0,  8'h3A, 8'hC6, 8'h00, 5'b01111},
        {2'd1, 4'd1,  8'h14, 8'h22, 8'h37, 5'b00000},
        {2'd1, 4'd0,  8'h14, 8'h22, 8'h36, 5'b00010},
        {2'd0, 4'd2,  8'h3E, 8'h3E, 8'h00, 5'b01010},
        {2'd0, 4'd2,  8'h10, 8'h20, 8'hF0, 5'b10011},
        {2'd1, 4'd3,  8'h50, 8'h0F, 8'h40, 5'b00100},
        {2'd0, 4'd3,  8'h50, 8'h0F, 8'h41, 5'b00110},
        {2'd3, 4'd4,  8'hF3, 8'h3C, 8'h30, 5'b00010},
        {2'd3, 4'd5,  8'h81, 8'h02, 8'h83, 5'b10000},
        {2'd1, 4'd6,  8'h5A, 8'h5A, 8'h00, 5'b01010},
        {2'd2, 4'd7,  8'hFF, 8'h12, 8'h00, 5'b00100},
        {2'd1, 4'd7,  8'h55, 8'h00, 8'hAA, 5'b01011},
        {2'd1, 4'd8,  8'h42, 8'h99, 8'h42, 5'b01010},
        {2'd0, 4'd8,  8'h42, 8'h99, 8'h42, 5'b01011},
        {2'd1, 4'd9,  8'h00, 8'hFF, 8'h00, 5'b01111},
        {2'd0, 4'd9,  8'h00, 8'h7F, 8'h80, 5'b10100},
        {2'd1, 4'd10, 8'h00, 8'h00, 8'hFF, 5'b10111},
        {2'd0, 4'd10, 8'h00, 8'h01, 8'h00, 5'b01010},
        {2'd0, 4'd11, 8'h9B, 8'h00, 8'h01, 5'b00101},
        {2'd2, 4'd11, 8'h12, 8'h00, 8'h18, 5'b00010},
        {2'd1, 4'd11, 8'h25, 8'h00, 8'h85, 5'b10001},
        {2'd0, 4'd11, 8'h45, 8'h00, 8'h45, 5'b00000},
        {2'd0, 4'd11, 8'hFA, 8'h00, 8'h60, 5'b00111},
        {2'd0, 4'd12, 8'h77, 8'h11, 8'h77, 5'b01010},
        {2'd3, 4'd15, 8'h3C, 8'h00, 8'h3C, 5'b01111}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] acc = 8'h00;
    logic [7:0] opnd = 8'h00;
    logic       we = 1'b0;
    logic [7:0] res;
    logic [4:0] flg;
    int         n_chk = 0;
    int         n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u0 (.clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
                .wr_en_i(we), .result_o(res), .flags_o(flg));

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1:        return "R2";
            4'd2, 4'd3:        return "R3";
            4'd4, 4'd5, 4'd6:  return "R4";
            4'd7:              return "R5";
            4'd8:              return "R6";
            4'd9, 4'd10:       return "R7";
            4'd11:             return "R8";
            default:           return "R11";
        endcase
    endfunction

    task automatic check(input string rq, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, got, exp);
        end
    endtask

    // Drive inputs at the falling edge; the result settles within the cycle, the flags follow the next rising edge.
    task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b, input logic w);
        @(negedge clk);
        op = o; acc = a; opnd = b; we = w;
        #1;
    endtask

    task automatic preset(input logic [1:0] p);
        case (p)
            2'd0: apply(4'd0, 8'h00, 8'h00, 1'b1);
            2'd1: apply(4'd0, 8'hF0, 8'h10, 1'b1);
            2'd2: apply(4'd0, 8'h0F, 8'h01, 1'b1);
            default: apply(4'd0, 8'hFF, 8'h01, 1'b1);
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        // R1: cleared after reset
        check("R1", "flags after reset", {3'b0, flg}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags before first write", {3'b0, flg}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [34:0] v;
            v = VEC[i];
            preset(v[34:33]);
            apply(v[32:29], v[28:21], v[20:13], 1'b1);
            check(req_of(v[32:29]), $sformatf("result vec %0d", i), res, v[12:5]);
            @(negedge clk);
            we = 1'b0;
            check((v[32:29] == 4'd7 || v[32:29] == 4'd8 || v[32:29] >= 4'd12) ? req_of(v[32:29]) : "R9",
                  $sformatf("flags vec %0d", i), {3'b0, flg}, {3'b0, v[4:0]});
        end

        // R10: strobe low keeps flags while the result still follows the inputs
        preset(2'd3);
        apply(4'd2, 8'h05, 8'h03, 1'b0);
        check("R10", "result without strobe", res, 8'h02);
        @(negedge clk);
        check("R10", "flags held without strobe", {3'b0, flg}, 8'h0F);
        @(posedge clk);
        #1;
        check("R10", "flags still held", {3'b0, flg}, 8'h0F);

        // R1: reset again clears written flags
        rst_n = 1'b0;
        #1;
        check("R1", "flags after second reset", {3'b0, flg}, 8'h00);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule